// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable slave that behaves like a small three-wire serial EEPROM holding 1 Kbit of storage. A host selects the device with a chip-select line, clocks bits in on a serial data input with a shift clock, and receives read data and ready/busy status on a serial data output. That output has a separate enable, and the enable is low whenever the output should float. A mode input chooses the layout of the storage: 64 words of 16 bits when high, or 128 bytes when low.

Every transaction opens with a 1 start bit, then a two-bit operation code, then an address field. The block supports reading a location, writing a location, erasing a location to all ones, erasing or writing the whole array, and enabling or disabling programming. Programming is protected by a latch that is clear after reset. Each programming operation is followed by a self-timed busy interval whose length is a parameter in system clock cycles. While that interval runs, the host can poll ready/busy on the output by taking chip-select low and then high again.

The shift clock and the data input pass through two-flop synchronisers. Their edges are detected in the system clock domain, so the shift clock has to run several times slower than the system clock.

Top module: `mwire_eeprom`

## Requirements
- R1: A transaction is a 1 start bit, an operation code, then an address field. The address field is 6 bits when `org`=1 (16-bit words) and 7 bits when `org`=0 (bytes). All bits are sampled on rising `sk`, MSB first. The codes are: 10 = read, 01 = write, 11 = erase. Code 00 takes its sub-command from the top two address bits: 11 = enable programming, 00 = disable programming, 10 = erase all, 01 = write all. The remaining address bits are ignored but must still be clocked.
- R2: On the rising `sk` that carries the last address bit of a read, the output is enabled and drives a 0 dummy bit. Each later rising `sk` presents the next data bit, MSB first: 16 bits in word mode and 8 in byte mode.
- R3: After reset, programming is disabled. The enable sub-command turns it on, and it stays on until the disable sub-command or reset. While programming is disabled, write, erase, erase-all and write-all leave the storage unchanged and start no busy interval. Reads work in both states.
- R4: A write stores the data field that follows the address. In byte mode, byte address b is half of word b>>1: the upper half when b[0]=0 and the lower half when b[0]=1.
- R5: Erase sets every bit of the addressed word (or byte) to 1.
- R6: Erase-all sets every location to all ones. Write-all stores its data field in every location.
- R7: A busy interval of exactly `PROG_CYCLES` clocks starts after the last data bit (write, write-all) or after the last address bit (erase, erase-all). A start bit sent during the busy interval is ignored.
- R8: If chip-select rises while busy, the output is enabled and drives 0 until the interval ends, then 1. If chip-select rises only after the interval has ended, the output stays disabled.
- R9: The output enable is low within three clocks of chip-select going low.
- R10: Taking chip-select low abandons a partly shifted transaction. The next transaction is framed from its own start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial shift clock, asynchronous to clk |
| di | input | 1 | Serial data into the device |
| org | input | 1 | Layout select: 1 = 16-bit words, 0 = bytes |
| do_out | output | 1 | Serial data / ready-busy value |
| do_oe | output | 1 | Output enable for do_out; low means high impedance |

## Verification
The bench builds the block with `PROG_CYCLES` = 400 and keeps the other parameters at their defaults. With that value the busy interval is longer than a whole erase transaction, so the bench can send an instruction in the middle of programming and show that it is rejected. The same value still lets the bench wait out every interval and measure it against the expected count. It also stays above the 64 cycles that the whole-array operations need to sweep every word.

// File: rtl/mwire_pkg.sv
package mwire_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_RWAIT,
    ST_RLOAD,
    ST_ROUT,
    ST_HOLD
  } mw_state_e;

  localparam logic [1:0] OP_SPECIAL = 2'b00;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] OP_ERASE   = 2'b11;

  localparam logic [1:0] SUB_LOCK   = 2'b00;
  localparam logic [1:0] SUB_FILL   = 2'b01;
  localparam logic [1:0] SUB_WIPE   = 2'b10;
  localparam logic [1:0] SUB_UNLOCK = 2'b11;

endpackage

// File: rtl/mwire_sync.sv
module mwire_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mwire_store.sv
module mwire_store #(
  parameter int NWORDS = 64,
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  localparam int WAW   = $clog2(NWORDS)
) (
  input  logic                    clk,
  input  logic [WAW-1:0]          addr,
  input  logic                    we,
  input  logic [LANES-1:0]        be,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  // One simple-port RAM per lane so each lane maps onto block RAM.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [NWORDS];
    always_ff @(posedge clk) begin
      if (we && be[l]) mem[addr] <= wdata[l*LANE_W +: LANE_W];
      rdata[l*LANE_W +: LANE_W] <= mem[addr];
    end
  end
endmodule

// File: rtl/mwire_prog_seq.sv
module mwire_prog_seq #(
  parameter int NWORDS      = 64,
  parameter int WORD_W      = 16,
  parameter int PROG_CYCLES = 5000,   // must be at least NWORDS
  localparam int WAW        = $clog2(NWORDS),
  localparam int CW         = $clog2(PROG_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              bulk,
  input  logic [WAW-1:0]    word,
  input  logic [WORD_W-1:0] data,
  input  logic [1:0]        be,
  output logic              busy,
  output logic              we,
  output logic [1:0]        we_be,
  output logic [WAW-1:0]    addr,
  output logic [WORD_W-1:0] wdata
);
  logic [CW-1:0]     cnt;
  logic              bulk_q;
  logic [WAW-1:0]    word_q;
  logic [WORD_W-1:0] data_q;
  logic [1:0]        be_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      bulk_q <= 1'b0;
      word_q <= '0;
      data_q <= '0;
      be_q   <= '0;
    end else if (go && !busy) begin
      busy   <= 1'b1;
      cnt    <= '0;
      bulk_q <= bulk;
      word_q <= word;
      data_q <= data;
      be_q   <= be;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (cnt == CW'(PROG_CYCLES - 1)) busy <= 1'b0;
    end
  end

  // Bulk operations sweep one word per cycle at the start of the interval.
  assign we    = busy && (bulk_q ? (cnt < CW'(NWORDS)) : (cnt == '0));
  assign addr  = bulk_q ? cnt[WAW-1:0] : word_q;
  assign we_be = be_q;
  assign wdata = data_q;
endmodule

// File: rtl/mwire_eeprom.sv
module mwire_eeprom
  import mwire_pkg::*;
#(
  parameter int ARRAY_BITS  = 1024,
  parameter int WORD_W      = 16,
  parameter int PROG_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic org,
  output logic do_out,
  output logic do_oe
);
  localparam int NWORDS = ARRAY_BITS / WORD_W;
  localparam int WAW    = $clog2(NWORDS);
  localparam int BW     = WORD_W / 2;
  localparam int HW     = WAW + 3;                 // opcode + byte-mode address
  localparam int CNTW   = $clog2(WORD_W + HW + 1);

  // Input synchronisation and edge detection
  logic [2:0] sync_q;
  logic cs_s, sk_s, di_s, sk_prev, cs_prev, sk_rise, cs_rise;

  mwire_sync #(.W(3), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d({cs, sk, di}), .q(sync_q)
  );
  assign {cs_s, sk_s, di_s} = sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sk_prev <= 1'b0;
      cs_prev <= 1'b0;
    end else begin
      sk_prev <= sk_s;
      cs_prev <= cs_s;
    end
  end
  assign sk_rise = sk_s & ~sk_prev;
  assign cs_rise = cs_s & ~cs_prev;

  // Shift state
  mw_state_e         st;
  logic [CNTW-1:0]   bcnt;
  logic [HW-2:0]     hdr_q;
  logic [WORD_W-2:0] dat_q;
  logic [WORD_W-1:0] out_sh;
  logic [WAW-1:0]    cur_word;
  logic [1:0]        cur_be;
  logic              cur_bulk;
  logic              wen;
  logic              stat_en;
  logic              do_q, do_oe_q;

  // Programming request
  logic              pg_go, pg_bulk;
  logic [WAW-1:0]    pg_word;
  logic [WORD_W-1:0] pg_data;
  logic [1:0]        pg_be;

  // Field decode (assumes org is steady during a transaction)
  logic [HW-1:0]     hdr_nx;
  logic [WORD_W-1:0] dat_nx, wr_word;
  logic [CNTW-1:0]   hdr_len, dat_len;
  logic [1:0]        op, sub, dec_be;
  logic [WAW-1:0]    dec_word;

  assign hdr_nx   = {hdr_q, di_s};
  assign dat_nx   = {dat_q, di_s};
  assign hdr_len  = org ? CNTW'(WAW + 2) : CNTW'(WAW + 3);
  assign dat_len  = org ? CNTW'(WORD_W) : CNTW'(BW);
  assign op       = org ? hdr_nx[WAW+1:WAW] : hdr_nx[WAW+2:WAW+1];
  assign sub      = org ? hdr_nx[WAW-1:WAW-2] : hdr_nx[WAW:WAW-1];
  assign dec_word = org ? hdr_nx[WAW-1:0] : hdr_nx[WAW:1];
  assign dec_be   = org ? 2'b11 : (hdr_nx[0] ? 2'b01 : 2'b10);
  assign wr_word  = org ? dat_nx : {2{dat_nx[BW-1:0]}};

  // Storage and programming timer
  logic              busy, mem_we;
  logic [1:0]        mem_be;
  logic [WAW-1:0]    seq_addr, mem_addr;
  logic [WORD_W-1:0] mem_wdata, mem_rdata;

  mwire_prog_seq #(.NWORDS(NWORDS), .WORD_W(WORD_W), .PROG_CYCLES(PROG_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .go(pg_go), .bulk(pg_bulk), .word(pg_word),
    .data(pg_data), .be(pg_be), .busy(busy), .we(mem_we), .we_be(mem_be),
    .addr(seq_addr), .wdata(mem_wdata)
  );

  assign mem_addr = busy ? seq_addr : cur_word;

  mwire_store #(.NWORDS(NWORDS), .LANE_W(BW), .LANES(2)) u_store (
    .clk(clk), .addr(mem_addr), .we(mem_we), .be(mem_be),
    .wdata(mem_wdata), .rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      bcnt     <= '0;
      hdr_q    <= '0;
      dat_q    <= '0;
      out_sh   <= '0;
      cur_word <= '0;
      cur_be   <= 2'b11;
      cur_bulk <= 1'b0;
      wen      <= 1'b0;
      stat_en  <= 1'b0;
      do_q     <= 1'b0;
      do_oe_q  <= 1'b0;
      pg_go    <= 1'b0;
      pg_bulk  <= 1'b0;
      pg_word  <= '0;
      pg_data  <= '0;
      pg_be    <= '0;
    end else begin
      pg_go <= 1'b0;
      if (!cs_s) begin
        st      <= ST_IDLE;
        bcnt    <= '0;
        stat_en <= 1'b0;
        do_oe_q <= 1'b0;
      end else begin
        if (cs_rise && busy) begin
          stat_en <= 1'b1;
          do_oe_q <= 1'b1;
        end
        if (stat_en) do_q <= ~busy;

        case (st)
          ST_IDLE: if (sk_rise && di_s && !busy) begin
            st      <= ST_HDR;
            bcnt    <= '0;
            stat_en <= 1'b0;
            do_oe_q <= 1'b0;
          end
          ST_HDR: if (sk_rise) begin
            hdr_q <= hdr_nx[HW-2:0];
            bcnt  <= bcnt + 1'b1;
            if (bcnt == hdr_len - 1'b1) begin
              cur_word <= dec_word;
              cur_be   <= dec_be;
              cur_bulk <= 1'b0;
              bcnt     <= '0;
              st       <= ST_HOLD;
              case (op)
                OP_READ: begin
                  st      <= ST_RWAIT;
                  do_q    <= 1'b0;
                  do_oe_q <= 1'b1;
                end
                OP_WRITE: if (wen) st <= ST_DATA;
                OP_ERASE: if (wen) begin
                  pg_go   <= 1'b1;
                  pg_bulk <= 1'b0;
                  pg_word <= dec_word;
                  pg_data <= '1;
                  pg_be   <= dec_be;
                end
                default: case (sub)
                  SUB_UNLOCK: wen <= 1'b1;
                  SUB_LOCK:   wen <= 1'b0;
                  SUB_WIPE: if (wen) begin
                    pg_go   <= 1'b1;
                    pg_bulk <= 1'b1;
                    pg_data <= '1;
                    pg_be   <= 2'b11;
                  end
                  default: if (wen) begin
                    st       <= ST_DATA;
                    cur_bulk <= 1'b1;
                  end
                endcase
              endcase
            end
          end
          ST_DATA: if (sk_rise) begin
            dat_q <= dat_nx[WORD_W-2:0];
            bcnt  <= bcnt + 1'b1;
            if (bcnt == dat_len - 1'b1) begin
              pg_go   <= 1'b1;
              pg_bulk <= cur_bulk;
              pg_word <= cur_word;
              pg_data <= wr_word;
              pg_be   <= cur_bulk ? 2'b11 : cur_be;
              st      <= ST_HOLD;
            end
          end
          ST_RWAIT: st <= ST_RLOAD;
          ST_RLOAD: begin
            out_sh <= org ? mem_rdata
                          : {(cur_be[1] ? mem_rdata[WORD_W-1:BW] : mem_rdata[BW-1:0]), {BW{1'b0}}};
            st     <= ST_ROUT;
          end
          ST_ROUT: if (sk_rise) begin
            do_q   <= out_sh[WORD_W-1];
            out_sh <= {out_sh[WORD_W-2:0], 1'b0};
            bcnt   <= bcnt + 1'b1;
            if (bcnt == dat_len - 1'b1) st <= ST_HOLD;
          end
          default: ;
        endcase
      end
    end
  end

  assign do_out = do_q;
  assign do_oe  = do_oe_q;
endmodule

// File: rtl/mwire_eeprom_chk.sv
module mwire_eeprom_chk
  import mwire_pkg::*;
#(
  parameter int PROG_CYCLES = 5000
) (
  input logic      clk,
  input logic      rst,
  input logic      cs_s,
  input logic      busy,
  input logic      wen,
  input logic      stat_en,
  input mw_state_e st,
  input logic      do_out,
  input logic      do_oe
);
  int unsigned busy_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_cnt <= 0;
    else              busy_cnt <= busy_cnt + 1;
  end

  // R9: a low chip select turns the output driver off on the next edge
  assert_oe_off_cs_low_R9: assert property (@(posedge clk) disable iff (rst)
    !cs_s |=> !do_oe);

  // R7: every busy interval lasts exactly PROG_CYCLES clocks
  assert_busy_len_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> busy_cnt == PROG_CYCLES);

  // R7: a transaction is never framed while programming is in progress
  assert_no_start_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HDR && $past(st) == ST_IDLE) |-> !$past(busy));

  // R3: programming only begins while the enable latch is set
  assert_prog_needs_en_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> wen);

  // R8: in status mode the output mirrors not-busy
  assert_status_val_R8: assert property (@(posedge clk) disable iff (rst)
    (stat_en && $past(stat_en)) |-> (do_oe && do_out == !$past(busy)));
endmodule

bind mwire_eeprom mwire_eeprom_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .cs_s(cs_s), .busy(busy), .wen(wen),
  .stat_en(stat_en), .st(st), .do_out(do_out), .do_oe(do_oe)
);

// File: tb/mwire_eeprom_bench.sv
module mwire_eeprom_bench;
  localparam int PROG = 400;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
  logic do_out, do_oe;
  int   checks = 0;
  int   errors = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  mwire_eeprom #(.PROG_CYCLES(PROG)) u_mwire_eeprom (
    .clk(clk), .rst(rst), .cs(cs), .sk(sk), .di(di), .org(org),
    .do_out(do_out), .do_oe(do_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sk_bit(input logic b);
    di = b; sk = 1'b0;
    repeat (HALF) @(negedge clk);
    sk = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sk_bit(v[i]);
  endtask

  task automatic cs_up();
    @(negedge clk); sk = 1'b0; cs = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic cs_down();
    sk = 1'b0; di = 1'b0; cs = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  function automatic int aw(input logic o); return o ? 6 : 7; endfunction
  function automatic int dw(input logic o); return o ? 16 : 8; endfunction
  function automatic logic [6:0] subaddr(input logic o, input logic [1:0] s);
    return o ? {1'b0, s, 4'b0} : {s, 5'b0};
  endfunction

  task automatic hdr(input logic o, input logic [1:0] op, input logic [6:0] a);
    org = o;
    send({29'd0, 1'b1, op}, 3);
    send({25'd0, a}, aw(o));
  endtask

  task automatic rd(input logic o, input logic [6:0] a, input logic [15:0] exp, input string tag);
    logic [15:0] d = '0;
    cs_up();
    hdr(o, 2'b10, a);
    chk({tag, " R2 dummy"}, {30'd0, do_oe, do_out}, 32'h2);
    for (int i = 0; i < dw(o); i++) begin
      sk_bit(1'b0);
      d = {d[14:0], do_out};
    end
    chk(tag, {16'd0, d}, {16'd0, exp});
    cs_down();
  endtask

  task automatic op_simple(input logic o, input logic [1:0] op, input logic [6:0] a);
    cs_up(); hdr(o, op, a); cs_down();
  endtask

  task automatic op_data(input logic o, input logic [1:0] op, input logic [6:0] a, input logic [15:0] d);
    cs_up(); hdr(o, op, a); send({16'd0, d}, dw(o)); cs_down();
  endtask

  task automatic wait_ready();
    repeat (PROG + 20) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R9 oe after reset", {31'd0, do_oe}, 0);
    cs_up();
    chk("R8 no status when idle", {31'd0, do_oe}, 0);
    cs_down();
    chk("R9 oe with cs low", {31'd0, do_oe}, 0);
  endtask

  task automatic t_enable_wipe();
    op_simple(1'b1, 2'b00, subaddr(1'b1, 2'b11));
    op_simple(1'b1, 2'b00, subaddr(1'b1, 2'b10));
    cs_up();
    chk("R8 busy status", {30'd0, do_oe, do_out}, 32'h2);
    wait_ready();
    chk("R8 ready status", {30'd0, do_oe, do_out}, 32'h3);
    cs_down();
    rd(1'b1, 7'd0, 16'hFFFF, "R6 erase-all word 0");
    rd(1'b1, 7'd63, 16'hFFFF, "R6 erase-all word 63");
    rd(1'b0, 7'd127, 16'h00FF, "R6 erase-all byte 127");
  endtask

  task automatic t_write_busy();
    op_data(1'b1, 2'b01, 7'd5, 16'hA53C);
    cs_up();
    chk("R8 status busy after write", {30'd0, do_oe, do_out}, 32'h2);
    hdr(1'b1, 2'b11, 7'd5);   // erase sent during programming
    cs_down();
    wait_ready();
    rd(1'b1, 7'd5, 16'hA53C, "R4 R7 write kept, erase in busy ignored");
    rd(1'b1, 7'd4, 16'hFFFF, "R4 neighbour untouched");
  endtask

  task automatic t_busy_len();
    int n = 0;
    cs_up(); hdr(1'b1, 2'b01, 7'd63); send(32'h8001, 16);
    sk = 1'b0; di = 1'b0; cs = 1'b0;
    repeat (3) @(negedge clk); n = HALF + 3;
    cs = 1'b1;
    repeat (5) @(negedge clk); n += 5;
    chk("R7 busy early", {30'd0, do_oe, do_out}, 32'h2);
    while (!(do_oe && do_out) && n < 2 * PROG) begin
      @(negedge clk); n++;
    end
    chk("R7 interval length window", {31'd0, (n >= PROG && n <= PROG + 10)}, 1);
    cs_down();
    rd(1'b1, 7'd63, 16'h8001, "R4 write top word");
  endtask

  task automatic t_erase();
    op_simple(1'b1, 2'b11, 7'd5);
    wait_ready();
    rd(1'b1, 7'd5, 16'hFFFF, "R5 erase word");
    op_simple(1'b0, 2'b11, 7'd127);
    wait_ready();
    rd(1'b1, 7'd63, 16'h80FF, "R5 erase odd byte");
  endtask

  task automatic t_bytes();
    op_data(1'b0, 2'b01, 7'd10, 16'h005A); wait_ready();
    op_data(1'b0, 2'b01, 7'd11, 16'h00C3);
    repeat (PROG + 20) @(negedge clk);
    cs_up();
    chk("R8 no status after ready", {31'd0, do_oe}, 0);
    cs_down();
    rd(1'b1, 7'd5, 16'h5AC3, "R4 byte placement");
    rd(1'b0, 7'd11, 16'h00C3, "R1 R4 byte read");
  endtask

  task automatic t_fill();
    op_data(1'b1, 2'b00, subaddr(1'b1, 2'b01), 16'h1E2D);
    wait_ready();
    rd(1'b1, 7'd0, 16'h1E2D, "R6 write-all word 0");
    rd(1'b1, 7'd31, 16'h1E2D, "R6 write-all word 31");
    rd(1'b1, 7'd63, 16'h1E2D, "R6 write-all word 63");
  endtask

  task automatic t_locked();
    op_simple(1'b1, 2'b00, subaddr(1'b1, 2'b00));
    op_data(1'b1, 2'b01, 7'd3, 16'h0000);
    cs_up();
    chk("R3 no busy when locked", {31'd0, do_oe}, 0);
    cs_down();
    op_simple(1'b1, 2'b11, 7'd4);
    op_simple(1'b0, 2'b00, subaddr(1'b0, 2'b10));
    wait_ready();
    rd(1'b1, 7'd3, 16'h1E2D, "R3 write ignored when locked");
    rd(1'b1, 7'd4, 16'h1E2D, "R3 erase ignored when locked");
  endtask

  task automatic t_abort();
    op_simple(1'b1, 2'b00, subaddr(1'b1, 2'b11));
    cs_up();
    send(32'b101, 3); send(32'b111, 3);
    cs_down();
    rd(1'b1, 7'd0, 16'h1E2D, "R10 abort then read");
    rd(1'b1, 7'd7, 16'h1E2D, "R10 aborted write had no effect");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_enable_wipe();
    t_write_busy();
    t_busy_len();
    t_erase();
    t_bytes();
    t_fill();
    t_locked();
    t_abort();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule